// File: doc/BRIEF.md
# Receive Packet Buffer with Status Header

This block sits between a receive MAC and a host. It takes a byte stream that already has the preamble removed and that still ends in a four-byte frame check sequence. It removes those check bytes, writes the remaining frame contents into a circular byte buffer, and puts a four-byte header in front of each stored packet. The header carries a status byte, a zero byte and the stored byte count.

The MAC marks the final byte of each frame and reports CRC and alignment errors with that byte. An errored frame is rolled back and never becomes visible to the host. When the keep-errored mode input is high, such a frame is stored instead, and its status byte records the errors. A frame that does not fit in the free space is always rolled back, and a one-cycle overflow pulse reports it. The host drains whole packets through a simple read port. Each packet comes out header first, then its payload in arrival order.

Top module: `rx_pkt_buffer`

## Requirements
- R1: For each frame, the final CRC_BYTES (default 4) received bytes are never stored. Every byte before them is stored and read back in arrival order.
- R2: Each stored packet is read out as its four header bytes, then its payload. Packets come out in the order their frames ended.
- R3: Header byte 0 is the status byte. Bit 0 is a CRC error, bit 1 an alignment error, bit 2 a short frame (stored count below MIN_LEN, default 60). Bit 3 marks overflow and is always 0 in a stored header. Bit 7 is good (no error bit set). Bits 4 to 6 are 0.
- R4: Header byte 1 is 0. Bytes 2 and 3 hold the stored payload count, low byte first, excluding the check bytes.
- R5: With acceptBad low, a frame with a CRC error, an alignment error or a short count leaves nothing readable. It also leaves later packets unaffected.
- R6: With acceptBad high, an errored frame that fits is stored, and its error bits are set in its status byte.
- R7: A frame whose header and payload do not fit in the free space is dropped in either mode. rxOverflow is high for exactly the one cycle after that frame's last byte is accepted. Packets stored earlier stay intact, and later frames are stored normally once space exists.
- R8: rdAvail is high only while committed, unread bytes exist. A kept packet becomes readable 4 cycles after its last byte is accepted. rdEn with rdAvail high returns the next byte on rdData, with rdValid high, in the following cycle.
- R9: Frames of at least 8 bytes may follow each other with no idle cycle between them, and each one is handled correctly.
- R10: After reset, rdAvail, rdValid and rxOverflow are low and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| acceptBad | input | 1 | Keep errored frames and flag their errors |
| rxValid | input | 1 | Receive byte valid |
| rxData | input | 8 | Receive byte |
| rxLast | input | 1 | Final byte of frame (last check byte) |
| rxCrcErr | input | 1 | CRC error, qualified by rxLast |
| rxAlignErr | input | 1 | Alignment error, qualified by rxLast |
| rdEn | input | 1 | Host read request |
| rdAvail | output | 1 | Committed unread data present |
| rdData | output | 8 | Read byte |
| rdValid | output | 1 | rdData valid |
| rxOverflow | output | 1 | One-cycle pulse: a frame was dropped for lack of space |

## Verification
Good frames of several lengths show that the check bytes are stripped and that the header count matches. CRC-errored, misaligned and short frames are sent with the mode low and then with it high. This separates rollback from flagged storage, and it shows each status bit on its own and in combination. The buffer is filled to exactly its capacity with back-to-back frames while the host is stalled, then one more frame is sent. This separates an exact fit from overflow and confirms that the pointer is restored. A check on when a packet becomes readable pins the header write-back latency.

// File: rtl/rxbuf_pkg.sv
`timescale 1ns/1ps
package rxbuf_pkg;
  localparam int HDR_BYTES = 4;
  localparam int LEN_W = 16;
  localparam int ST_CRC = 0;
  localparam int ST_ALIGN = 1;
  localparam int ST_SHORT = 2;
  localparam int ST_OVF = 3;
  localparam int ST_GOOD = 7;

  // strobes from control to datapath
  typedef struct packed {
    logic       payWr;
    logic       keep;
    logic       drop;
    logic       hdrWr;
    logic [1:0] hdrIdx;
    logic       publish;
    logic [7:0] hdrStat;
  } ctl_t;
endpackage

// File: rtl/rxbuf_dp.sv
`timescale 1ns/1ps
module rxbuf_dp
  import rxbuf_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int CRC_BYTES = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1,
  localparam int FW = $clog2(CRC_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxValid,
  input  logic [7:0]       rxData,
  input  logic             rxLast,
  input  ctl_t             ctl,
  input  logic             rdEn,
  output logic             dlFull,
  output logic [PW-1:0]    used,
  output logic [LEN_W-1:0] payLen,
  output logic             rdAvail,
  output logic [7:0]       rdData,
  output logic             rdValid
);
  logic [7:0]       dl [CRC_BYTES];
  logic [FW-1:0]    fill;
  logic [7:0]       mem [DEPTH];
  logic [PW-1:0]    wrPtr, frameBase, cmtPtr, rdPtr, hdrBase, wrNext;
  logic [LEN_W-1:0] hdrLen, lenNext;
  logic [AW-1:0]    hdrAddr;
  logic [7:0]       hdrByte;

  // delay line that holds back the trailing check bytes
  always_ff @(posedge clk) if (rxValid) dl[0] <= rxData;
  for (genvar g = 1; g < CRC_BYTES; g++) begin : g_dly
    always_ff @(posedge clk) if (rxValid) dl[g] <= dl[g-1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) fill <= '0;
    else if (rxValid) begin
      if (rxLast) fill <= '0;
      else if (fill != FW'(CRC_BYTES)) fill <= fill + 1'b1;
    end
  end
  assign dlFull = (fill == FW'(CRC_BYTES));

  assign wrNext  = wrPtr + PW'(ctl.payWr);
  assign lenNext = payLen + LEN_W'(ctl.payWr);
  assign used    = wrPtr - rdPtr;
  assign rdAvail = (cmtPtr != rdPtr);
  assign hdrAddr = hdrBase[AW-1:0] + AW'(ctl.hdrIdx);

  always_comb begin
    case (ctl.hdrIdx)
      2'd0:    hdrByte = ctl.hdrStat;
      2'd1:    hdrByte = 8'h00;
      2'd2:    hdrByte = hdrLen[7:0];
      default: hdrByte = hdrLen[15:8];
    endcase
  end

  always_ff @(posedge clk) begin
    if (ctl.hdrWr) mem[hdrAddr] <= hdrByte;
    else if (ctl.payWr) mem[wrPtr[AW-1:0]] <= dl[CRC_BYTES-1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= PW'(HDR_BYTES);
      frameBase <= '0;
      cmtPtr    <= '0;
      rdPtr     <= '0;
      hdrBase   <= '0;
      hdrLen    <= '0;
      payLen    <= '0;
      rdData    <= '0;
      rdValid   <= 1'b0;
    end else begin
      if (ctl.keep) begin
        hdrBase   <= frameBase;
        hdrLen    <= lenNext;
        frameBase <= wrNext;
        wrPtr     <= wrNext + PW'(HDR_BYTES);
        payLen    <= '0;
      end else if (ctl.drop) begin
        wrPtr  <= frameBase + PW'(HDR_BYTES);
        payLen <= '0;
      end else if (ctl.payWr) begin
        wrPtr  <= wrNext;
        payLen <= lenNext;
      end
      if (ctl.publish) cmtPtr <= frameBase;
      rdValid <= 1'b0;
      if (rdEn && rdAvail) begin
        rdData  <= mem[rdPtr[AW-1:0]];
        rdPtr   <= rdPtr + 1'b1;
        rdValid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rxbuf_ctl.sv
`timescale 1ns/1ps
module rxbuf_ctl
  import rxbuf_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int MIN_LEN = 60,
  localparam int PW = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             acceptBad,
  input  logic             rxValid,
  input  logic             rxLast,
  input  logic             rxCrcErr,
  input  logic             rxAlignErr,
  input  logic             dlFull,
  input  logic [PW-1:0]    used,
  input  logic [LEN_W-1:0] payLen,
  output ctl_t             ctl,
  output logic             rxOverflow
);
  typedef enum logic {ST_RECV, ST_HDR} state_t;
  state_t     state;
  logic [1:0] hdrCnt;
  logic       frmOvf;
  logic [7:0] statReg;

  logic wantWr, room, ovfNow, endNow, endOvf, isShort, good;
  logic [PW-1:0]    usedAfter;
  logic [LEN_W-1:0] lenFinal;
  logic [7:0]       statNow;

  always_comb begin
    wantWr    = rxValid && dlFull && !frmOvf;
    room      = used < PW'(DEPTH);
    ovfNow    = frmOvf || (wantWr && !room);
    endNow    = rxValid && rxLast;
    usedAfter = used + PW'(wantWr && room);
    lenFinal  = payLen + LEN_W'(wantWr && room);
    endOvf    = ovfNow || (usedAfter > PW'(DEPTH));
    isShort   = lenFinal < LEN_W'(MIN_LEN);
    good      = !(rxCrcErr || rxAlignErr || isShort || endOvf);
    statNow   = '0;
    statNow[ST_CRC]   = rxCrcErr;
    statNow[ST_ALIGN] = rxAlignErr;
    statNow[ST_SHORT] = isShort;
    statNow[ST_OVF]   = endOvf;
    statNow[ST_GOOD]  = good;

    ctl.payWr   = wantWr && room;
    ctl.keep    = endNow && !endOvf && (good || acceptBad);
    ctl.drop    = endNow && !ctl.keep;
    ctl.hdrWr   = (state == ST_HDR);
    ctl.hdrIdx  = hdrCnt;
    ctl.publish = (state == ST_HDR) && (hdrCnt == 2'd3);
    ctl.hdrStat = statReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_RECV;
      hdrCnt     <= '0;
      frmOvf     <= 1'b0;
      statReg    <= '0;
      rxOverflow <= 1'b0;
    end else begin
      rxOverflow <= endNow && endOvf;
      if (endNow) frmOvf <= 1'b0;
      else if (ovfNow) frmOvf <= 1'b1;
      if (ctl.keep) statReg <= statNow;
      case (state)
        ST_RECV: if (ctl.keep) begin
          state  <= ST_HDR;
          hdrCnt <= '0;
        end
        default: begin
          hdrCnt <= hdrCnt + 1'b1;
          if (hdrCnt == 2'd3) state <= ST_RECV;
        end
      endcase
    end
  end
endmodule

// File: rtl/rx_pkt_buffer.sv
`timescale 1ns/1ps
module rx_pkt_buffer
  import rxbuf_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int CRC_BYTES = 4,
  parameter int MIN_LEN = 60
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       acceptBad,
  input  logic       rxValid,
  input  logic [7:0] rxData,
  input  logic       rxLast,
  input  logic       rxCrcErr,
  input  logic       rxAlignErr,
  input  logic       rdEn,
  output logic       rdAvail,
  output logic [7:0] rdData,
  output logic       rdValid,
  output logic       rxOverflow
);
  localparam int PW = $clog2(DEPTH) + 1;

  ctl_t             ctl;
  logic             dlFull;
  logic [PW-1:0]    used;
  logic [LEN_W-1:0] payLen;

  rxbuf_ctl #(.DEPTH(DEPTH), .MIN_LEN(MIN_LEN)) u_ctl (
    .clk(clk), .rstN(rstN), .acceptBad(acceptBad), .rxValid(rxValid),
    .rxLast(rxLast), .rxCrcErr(rxCrcErr), .rxAlignErr(rxAlignErr),
    .dlFull(dlFull), .used(used), .payLen(payLen), .ctl(ctl),
    .rxOverflow(rxOverflow)
  );

  rxbuf_dp #(.DEPTH(DEPTH), .CRC_BYTES(CRC_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData),
    .rxLast(rxLast), .ctl(ctl), .rdEn(rdEn), .dlFull(dlFull), .used(used),
    .payLen(payLen), .rdAvail(rdAvail), .rdData(rdData), .rdValid(rdValid)
  );
endmodule

// File: rtl/rx_pkt_buffer_chk.sv
`timescale 1ns/1ps
module rx_pkt_buffer_chk
  import rxbuf_pkg::*;
(
  input logic clk,
  input logic rstN,
  input logic acceptBad,
  input logic rxValid,
  input logic rxLast,
  input logic rdEn,
  input logic rdAvail,
  input logic rdValid,
  input logic rxOverflow,
  input ctl_t ctl
);
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(rdEn && rdAvail)); // R8
  AST_AVAIL_AFTER_HDR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdAvail) |-> $past(ctl.publish)); // R8
  AST_OVF_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    rxOverflow |-> $past(rxValid && rxLast)); // R7
  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rstN)
    ctl.hdrWr |-> !ctl.payWr); // R9
  AST_DROP_NO_HDR: assert property (@(posedge clk) disable iff (!rstN)
    ctl.drop |=> !ctl.hdrWr); // R5
  AST_KEEP_HDR: assert property (@(posedge clk) disable iff (!rstN)
    ctl.keep |=> (ctl.hdrWr && ctl.hdrIdx == 2'd0)); // R2
  AST_GOOD_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.keep && !acceptBad) |=> ctl.hdrStat[ST_GOOD]); // R5
endmodule

bind rx_pkt_buffer rx_pkt_buffer_chk u_chk (
  .clk(clk), .rstN(rstN), .acceptBad(acceptBad), .rxValid(rxValid),
  .rxLast(rxLast), .rdEn(rdEn), .rdAvail(rdAvail), .rdValid(rdValid),
  .rxOverflow(rxOverflow), .ctl(ctl)
);

// File: tb/rx_pkt_buffer_tb.sv
`timescale 1ns/1ps
module rx_pkt_buffer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MIN_LEN = 60;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic acceptBad = 1'b0;
  logic rxValid = 1'b0;
  logic [7:0] rxData = '0;
  logic rxLast = 1'b0;
  logic rxCrcErr = 1'b0;
  logic rxAlignErr = 1'b0;
  logic rdEn = 1'b0;
  logic rdAvail, rdValid, rxOverflow;
  logic [7:0] rdData;

  int checks = 0;
  int errors = 0;
  bit hostOn = 1'b0;
  logic [7:0] expQ [$];
  string reqQ [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_pkt_buffer u_dut (
    .clk(clk), .rstN(rstN), .acceptBad(acceptBad), .rxValid(rxValid),
    .rxData(rxData), .rxLast(rxLast), .rxCrcErr(rxCrcErr),
    .rxAlignErr(rxAlignErr), .rdEn(rdEn), .rdAvail(rdAvail),
    .rdData(rdData), .rdValid(rdValid), .rxOverflow(rxOverflow)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] payByte(input int n, input int i);
    return 8'((n * 13 + i * 7 + 3) & 255);
  endfunction

  function automatic void push(input logic [7:0] b, input string r);
    expQ.push_back(b);
    reqQ.push_back(r);
  endfunction

  // driver: sends one frame (n payload bytes + 4 check bytes), records expectations
  task automatic sendFrame(input int n, input bit crc, input bit aln,
                           input bit expKeep, input bit expOvf);
    logic [7:0] st;
    bit shortF;
    logic [15:0] len16;
    shortF = (n < MIN_LEN);
    len16 = 16'(n);
    st = {~(crc | aln | shortF), 3'b000, 1'b0, shortF, aln, crc};
    if (expKeep) begin
      push(st, "R3");
      push(8'h00, "R4");
      push(len16[7:0], "R4");
      push(len16[15:8], "R4");
      for (int i = 0; i < n; i++) push(payByte(n, i), "R1");
    end
    for (int i = 0; i < n + 4; i++) begin
      rxValid = 1'b1;
      rxData = (i < n) ? payByte(n, i) : 8'(8'hE0 + i);
      rxLast = (i == n + 3);
      rxCrcErr = rxLast & crc;
      rxAlignErr = rxLast & aln;
      @(negedge clk);
    end
    check(rxOverflow == expOvf, "R7", int'(rxOverflow), int'(expOvf));
    rxValid = 1'b0;
    rxLast = 1'b0;
    rxCrcErr = 1'b0;
    rxAlignErr = 1'b0;
  endtask

  task automatic waitDrain(input string req);
    int guard;
    guard = 0;
    while ((expQ.size() != 0 || rdAvail) && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    repeat (8) @(negedge clk);
    check(expQ.size() == 0, req, expQ.size(), 0);
    check(rdAvail == 1'b0, req, int'(rdAvail), 0);
  endtask

  // monitor: host side, pops and compares
  always @(negedge clk) begin
    if (rstN) begin
      if (rdValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R5", int'(rdData), -1);
        end else begin
          logic [7:0] e;
          string r;
          e = expQ.pop_front();
          r = reqQ.pop_front();
          check(rdData == e, r, int'(rdData), int'(e));
        end
      end
      rdEn = hostOn && rdAvail;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!rdAvail && !rdValid && !rxOverflow, "R10",
          {rdAvail, rdValid, rxOverflow}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(rdAvail == 1'b0, "R10", int'(rdAvail), 0);

    // good frames, host draining (R1, R2, R4)
    hostOn = 1'b1;
    sendFrame(60, 0, 0, 1, 0);
    sendFrame(100, 0, 0, 1, 0);
    sendFrame(137, 0, 0, 1, 0);
    waitDrain("R2");

    // errored frames dropped by default (R5)
    sendFrame(80, 1, 0, 0, 0);
    sendFrame(80, 0, 1, 0, 0);
    sendFrame(20, 0, 0, 0, 0);
    sendFrame(64, 0, 0, 1, 0);
    waitDrain("R5");

    // errored frames kept and flagged (R6, R3)
    acceptBad = 1'b1;
    sendFrame(80, 1, 0, 1, 0);
    sendFrame(70, 1, 1, 1, 0);
    sendFrame(20, 0, 0, 1, 0);
    sendFrame(30, 1, 0, 1, 0);
    sendFrame(61, 0, 0, 1, 0);
    waitDrain("R6");
    acceptBad = 1'b0;

    // fill to exact capacity with host stalled, back to back (R8, R9, R7)
    hostOn = 1'b0;
    sendFrame(60, 0, 0, 1, 0);
    repeat (3) @(negedge clk);
    check(rdAvail == 1'b0, "R8", int'(rdAvail), 0);
    @(negedge clk);
    check(rdAvail == 1'b1, "R8", int'(rdAvail), 1);
    sendFrame(60, 0, 0, 1, 0);
    sendFrame(60, 0, 0, 1, 0);
    sendFrame(60, 0, 0, 1, 0);
    sendFrame(60, 0, 0, 0, 1);
    @(negedge clk);
    check(rxOverflow == 1'b0, "R7", int'(rxOverflow), 0);
    acceptBad = 1'b1;
    sendFrame(40, 1, 0, 0, 1);
    acceptBad = 1'b0;
    hostOn = 1'b1;
    waitDrain("R7");
    sendFrame(90, 0, 0, 1, 0);
    waitDrain("R7");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule